// File: doc/BRIEF.md
# Address Router with Base Relocation

This block connects one bus master to several slaves. Each request address is compared against a set of address windows, one window per slave. A window is defined by a base address and a size. The request is forwarded to the slave whose window holds the address. Before forwarding, the window's base is subtracted, so every slave sees offsets that start at zero. A slave can therefore be moved in the address map by changing only its base parameter.

The default map has two slaves:
- Slave 0 is a 5 MiB main memory at address zero.
- Slave 1 is a one-word lock register placed directly after the memory.

One request may be outstanding at a time. The reply comes back from the slave that took the request. An address outside every window is not forwarded; instead it gets an error reply.

Top module: `addr_router`

## Requirements
- R1: After reset, `m_ready` is 1, `rsp_valid` is 0 and no bit of `s_valid` is set while `m_valid` is 0.
- R2: A request is accepted when `m_valid` and `m_ready` are both 1. In that same cycle, `s_valid[i]` is set only for the slave whose window [base_i, base_i + size_i) holds `m_addr`.
- R3: The selected slave's `s_addr` slice equals `m_addr` minus that slave's base address.
- R4: The selected slave receives `m_we` and `m_wdata` unchanged. Every other slave sees 0 on its `s_valid`, `s_we`, `s_addr` and `s_wdata`.
- R5: With the default parameters:
  - slave 0 covers 0x000000 to 0x4FFFFF;
  - slave 1 covers 0x500000 to 0x500003, so 0x500000 reaches slave 1 as offset 0;
  - every address from 0x500004 upward is unmapped.
- R6: An accepted unmapped request sets no `s_valid` bit. In the next cycle it gives `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0.
- R7: For a mapped request, `rsp_valid` is 1 with `rsp_err`=0 in exactly the cycle the selected slave raises `s_ack`. `rsp_rdata` equals that slave's `s_rdata` slice. An `s_ack` from any other slave has no effect.
- R8: `m_ready` is 0 from the cycle after acceptance through the reply cycle, and returns to 1 in the cycle after the reply. A request presented while `m_ready` is 0 is not forwarded.
- R9: At most one bit of `s_valid` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Master request valid |
| m_we | input | 1 | Master write enable |
| m_addr | input | AW | Master byte address |
| m_wdata | input | DW | Master write data |
| m_ready | output | 1 | Router can take a request |
| rsp_valid | output | 1 | Reply valid |
| rsp_err | output | 1 | Reply is an unmapped-address error |
| rsp_rdata | output | DW | Reply read data |
| s_valid | output | NS | Per-slave request strobe |
| s_we | output | NS | Per-slave write enable |
| s_addr | output | NS*AW | Per-slave zero-based offset |
| s_wdata | output | NS*DW | Per-slave write data |
| s_ack | input | NS | Per-slave reply strobe |
| s_rdata | input | NS*DW | Per-slave read data |

## Verification
The bench drives three kinds of address:
- Window edges: the first and last memory byte, the first and last lock byte, and the first unmapped byte. These separate off-by-one faults in the window compare from faults in the base subtraction.
- A stride sweep across the whole 24-bit space. It mixes memory, lock and unmapped addresses, each with a distinct write pattern.
- A stimulus that pokes the router while a request is outstanding. Each poke carries a second request and an acknowledge from the other slave. Neither may leak through.

The two slaves answer with different latencies. This shows whether the reply is taken from the slave that holds the request rather than from whichever slave answers first.

// File: rtl/router_pkg.sv
package router_pkg;

  // True when addr lies inside [base, base + size); written so that
  // base + size never has to be formed and cannot wrap.
  function automatic logic region_hit(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input logic [31:0] size);
    return (addr >= base) && ((addr - base) < size);
  endfunction

  // Zero-based offset seen by a slave.
  function automatic logic [31:0] region_offset(input logic [31:0] addr,
                                                input logic [31:0] base);
    return addr - base;
  endfunction

endpackage

// File: rtl/region_decoder.sv
module region_decoder
  import router_pkg::*;
#(
  parameter int NS = 2,
  parameter int AW = 24,
  parameter int IW = 1,
  parameter logic [NS*AW-1:0] BASE = {24'h500000, 24'h000000},
  parameter logic [NS*AW-1:0] SIZE = {24'h000004, 24'h500000}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  output logic [NS-1:0]    hit,
  output logic [IW-1:0]    sel_idx,
  output logic             any_hit,
  output logic [NS*AW-1:0] offs
);

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_win
      localparam logic [AW-1:0] WBASE = BASE[g*AW +: AW];
      localparam logic [AW-1:0] WSIZE = SIZE[g*AW +: AW];
      assign hit[g] = region_hit(32'(addr), 32'(WBASE), 32'(WSIZE));
      assign offs[g*AW +: AW] = AW'(region_offset(32'(addr), 32'(WBASE)));
    end
  endgenerate

  assign any_hit = |hit;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NS; i++) begin
      if (hit[i]) sel_idx = sel_idx | IW'(i);
    end
  end

  // Windows must not overlap: any address matches at most one.
  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R2

endmodule

// File: rtl/req_steer.sv
module req_steer #(
  parameter int NS = 2,
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [NS-1:0]    hit,
  input  logic [NS*AW-1:0] offs,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [NS-1:0]    s_valid,
  output logic [NS-1:0]    s_we,
  output logic [NS*AW-1:0] s_addr,
  output logic [NS*DW-1:0] s_wdata
);

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_port
      logic fire;
      assign fire                = accept & hit[g];
      assign s_valid[g]          = fire;
      assign s_we[g]             = fire & we;
      assign s_addr[g*AW +: AW]  = fire ? offs[g*AW +: AW] : '0;
      assign s_wdata[g*DW +: DW] = fire ? wdata : '0;
    end
  endgenerate

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_valid)); // R9

endmodule

// File: rtl/rsp_tracker.sv
module rsp_tracker #(
  parameter int NS = 2,
  parameter int DW = 32,
  parameter int IW = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             any_hit,
  input  logic [IW-1:0]    sel_idx,
  input  logic [NS-1:0]    s_ack,
  input  logic [NS*DW-1:0] s_rdata,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata
);

  logic          busy_q, err_q;
  logic [IW-1:0] pend_q;
  logic          ack_sel;
  logic [DW-1:0] rd_sel;

  // Pick the reply lines of the slave that owns the pending request.
  always_comb begin
    ack_sel = 1'b0;
    rd_sel  = '0;
    for (int i = 0; i < NS; i++) begin
      if (pend_q == IW'(i)) begin
        ack_sel = s_ack[i];
        rd_sel  = s_rdata[i*DW +: DW];
      end
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = busy_q & (err_q | ack_sel);
  assign rsp_err   = busy_q & err_q;
  assign rsp_rdata = (busy_q && !err_q && ack_sel) ? rd_sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      err_q  <= ~any_hit;
      pend_q <= sel_idx;
    end else if (rsp_valid) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end
  end

  AST_ERR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> (rsp_valid && rsp_err)); // R6
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy); // R8

endmodule

// File: rtl/addr_router.sv
module addr_router
  import router_pkg::*;
#(
  parameter int NS = 2,
  parameter int AW = 24,
  parameter int DW = 32,
  parameter logic [NS*AW-1:0] SLV_BASE = {24'h500000, 24'h000000},
  parameter logic [NS*AW-1:0] SLV_SIZE = {24'h000004, 24'h500000}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_valid,
  input  logic             m_we,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  output logic             m_ready,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic [NS-1:0]    s_valid,
  output logic [NS-1:0]    s_we,
  output logic [NS*AW-1:0] s_addr,
  output logic [NS*DW-1:0] s_wdata,
  input  logic [NS-1:0]    s_ack,
  input  logic [NS*DW-1:0] s_rdata
);

  localparam int IW = (NS > 1) ? $clog2(NS) : 1;

  logic             accept;
  logic             busy;
  logic [NS-1:0]    hit;
  logic [IW-1:0]    sel_idx;
  logic             any_hit;
  logic [NS*AW-1:0] offs;

  assign m_ready = ~busy;
  assign accept  = m_valid & m_ready;

  region_decoder #(
    .NS(NS), .AW(AW), .IW(IW), .BASE(SLV_BASE), .SIZE(SLV_SIZE)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(m_addr), .hit(hit),
    .sel_idx(sel_idx), .any_hit(any_hit), .offs(offs)
  );

  req_steer #(.NS(NS), .AW(AW), .DW(DW)) u_steer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hit(hit), .offs(offs),
    .we(m_we), .wdata(m_wdata), .s_valid(s_valid), .s_we(s_we),
    .s_addr(s_addr), .s_wdata(s_wdata)
  );

  rsp_tracker #(.NS(NS), .DW(DW), .IW(IW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .any_hit(any_hit),
    .sel_idx(sel_idx), .s_ack(s_ack), .s_rdata(s_rdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  AST_NO_FWD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ready |-> (s_valid == '0)); // R8
  AST_RSP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !m_ready); // R7
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !any_hit) |-> (s_valid == '0)); // R6

endmodule

// File: tb/tb_addr_router.sv
module tb_addr_router;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int AW = 24;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             m_valid = 1'b0;
  logic             m_we = 1'b0;
  logic [AW-1:0]    m_addr = '0;
  logic [DW-1:0]    m_wdata = '0;
  logic             m_ready;
  logic             rsp_valid;
  logic             rsp_err;
  logic [DW-1:0]    rsp_rdata;
  logic [NS-1:0]    s_valid;
  logic [NS-1:0]    s_we;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_wdata;
  logic [NS-1:0]    s_ack = '0;
  logic [NS*DW-1:0] s_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_router dut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .s_valid(s_valid), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Default map stated in R5: -1 means unmapped.
  function automatic int exp_slave(input logic [AW-1:0] a);
    if (a < 24'h500000) return 0;
    if (a < 24'h500004) return 1;
    return -1;
  endfunction

  task automatic access(input logic [AW-1:0] a, input bit we,
                        input logic [DW-1:0] wd, input bit poke);
    int slv;
    int oth;
    int lat;
    logic [AW-1:0] off;
    logic [DW-1:0] rd;
    slv = exp_slave(a);
    off = (slv == 1) ? a - 24'h500000 : a;
    oth = (slv == 0) ? 1 : 0;
    @(negedge clk);
    m_valid = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
    #1;
    chk(m_ready == 1'b1, "R8 ready when idle", 32'(m_ready), 32'h1);
    if (slv < 0) begin
      chk(s_valid == '0, "R6 unmapped not forwarded", 32'(s_valid), 32'h0);
    end else begin
      chk(s_valid == 2'(1 << slv), "R2/R5 slave select", 32'(s_valid), 32'(1 << slv));
      chk(s_addr[slv*AW +: AW] == off, "R3 offset", 32'(s_addr[slv*AW +: AW]), 32'(off));
      chk(s_we[slv] == we, "R4 write enable", 32'(s_we[slv]), 32'(we));
      chk(s_wdata[slv*DW +: DW] == wd, "R4 write data", s_wdata[slv*DW +: DW], wd);
      chk(s_we[oth] == 1'b0 && s_addr[oth*AW +: AW] == '0 && s_wdata[oth*DW +: DW] == '0,
          "R4 other slave quiet", s_wdata[oth*DW +: DW], 32'h0);
    end
    @(posedge clk); #1;
    m_valid = 1'b0;
    if (slv < 0) begin
      chk(rsp_valid && rsp_err && rsp_rdata == '0, "R6 error reply",
          {rsp_valid, rsp_err, 30'(rsp_rdata)}, 32'hC0000000);
      @(posedge clk); #1;
      chk(m_ready && !rsp_valid, "R8 release after error", 32'(m_ready), 32'h1);
    end else begin
      lat = (slv == 0) ? 2 : 1;
      for (int c = 0; c < lat; c++) begin
        chk(!rsp_valid && !m_ready, "R8 held while pending",
            {30'h0, rsp_valid, m_ready}, 32'h0);
        if (poke && c == 0) begin
          m_valid = 1'b1; m_addr = 24'h500000;
          s_ack[oth] = 1'b1;
          #1;
          chk(s_valid == '0, "R8 request ignored while busy", 32'(s_valid), 32'h0);
          chk(!rsp_valid, "R7 foreign ack ignored", 32'(rsp_valid), 32'h0);
        end
        @(posedge clk); #1;
        m_valid = 1'b0; s_ack = '0;
      end
      rd = (slv == 0) ? {8'hA0, off} : {8'hB1, off};
      s_rdata[slv*DW +: DW] = rd;
      s_rdata[oth*DW +: DW] = 32'hDEADBEEF;
      s_ack[slv] = 1'b1;
      #1;
      chk(rsp_valid && !rsp_err, "R7 reply on ack", {30'h0, rsp_valid, rsp_err}, 32'h2);
      chk(rsp_rdata == rd, "R7 reply data", rsp_rdata, rd);
      @(posedge clk); #1;
      s_ack = '0;
      chk(m_ready && !rsp_valid, "R8 release after reply", 32'(m_ready), 32'h1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(m_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset idle",
        {30'h0, m_ready, rsp_valid}, 32'h2);
    chk(s_valid == '0, "R1 no strobe in reset", 32'(s_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_ready == 1'b1 && s_valid == '0, "R1 idle after reset", 32'(m_ready), 32'h1);

    // R5 window edges
    access(24'h000000, 1'b0, 32'h0, 1'b0);
    access(24'h4FFFFF, 1'b1, 32'h11112222, 1'b0);
    access(24'h4FFFFC, 1'b0, 32'h0, 1'b1);
    access(24'h500000, 1'b0, 32'h0, 1'b1);
    access(24'h500000, 1'b1, 32'h00000000, 1'b0);
    access(24'h500003, 1'b1, 32'h5A5A5A5A, 1'b0);
    access(24'h500004, 1'b0, 32'h0, 1'b0);
    access(24'hFFFFFF, 1'b1, 32'h33334444, 1'b0);
    // Stride sweep over the full space
    for (int k = 0; k < 64; k++) begin
      access(AW'(k * 32'h40_3F01), k[0], 32'hC0DE0000 + 32'(k), k[2]);
    end
    for (int k = 0; k < 8; k++) begin
      access(24'h4FFFF8 + AW'(k * 2), k[1], 32'h0F0F0000 ^ 32'(k), 1'b0);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule